// File: doc/BRIEF.md
# SDRAM Auto Refresh Scheduler

This block keeps a two-bank SDRAM refreshed while sharing the command bus with the main access scheduler. An interval timer earns refresh credits. In distributed mode it earns one credit per short interval. In burst mode it earns a whole batch of credits per long retention period. Credits that cannot be served at once, because the main scheduler still holds the bus, pile up in a saturating pending counter.

While credits are pending, the block raises a bus request and waits for a grant. Once granted, it first closes any open bank with a precharge-all command and waits the precharge time. It then issues auto refresh commands back to back. After each refresh it holds NOPs for the refresh cycle time, and it returns the bus once the credits are used up. All cycle counts come from elaboration-time parameters: picoseconds divided by the clock period, rounded up. Row addressing stays inside the memory.

Top module: `sdram_refresh_sched`

## Requirements
- R1: The refresh-cycle and precharge waits in clocks are the ceiling of the time parameter divided by the clock period. For example, 70 ns at 20 ns gives 4, and 50 ns at 20 ns gives 3.
- R2: In distributed mode (`burst_mode_i`=0) one credit is earned every `ceil(TREFI_PS/CLK_PERIOD_PS)` clocks. With no traffic, `req_o` first rises that many clocks plus one after reset release.
- R3: In burst mode (`burst_mode_i`=1) `BURST_CNT` credits are earned together every `ceil(TREF_PS/CLK_PERIOD_PS)` clocks. They are all served in one bus tenure.
- R4: `req_o` is high exactly while the block wants or owns the bus. Before the grant is sampled, the command pins show deselect ({cs_n,ras_n,cas_n,we_n}=1111, a10=0).
- R5: The first command appears in the clock that follows the edge on which `gnt_i` is sampled high while requesting.
- R6: If any bit of `bank_open_i` is set when a command is chosen, the block issues precharge-all ({cs_n,ras_n,cas_n,we_n}=0010, a10=1). It decides again after the precharge wait, and precharges again if a bank is still open.
- R7: Auto refresh is {cs_n,ras_n,cas_n,we_n}=0001 with a10=0. It is only issued while `bank_open_i` is all zero. `cke_o` is high at all times.
- R8: Each command is followed by NOP ({cs_n,ras_n,cas_n,we_n}=0111) for the rest of its wait. The next command, or the fall of `req_o`, comes exactly the wait length after it.
- R9: Credits earned while the grant is withheld are all served back to back. A credit earned on the same edge that a refresh is issued is neither lost nor doubled.
- R10: The pending count saturates at `PEND_MAX`.
- R11: An active-low asynchronous reset clears the request and returns the pins to deselect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_mode_i | input | 1 | 0 distributed, 1 burst refresh |
| bank_open_i | input | NUM_BANKS | One bit per bank, set while the bank has an open row |
| gnt_i | input | 1 | Bus grant from the main access scheduler |
| req_o | output | 1 | Bus request / ownership |
| cke_o | output | 1 | Clock enable, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | All-banks flag for precharge |

## Verification
Two things can land on the same clock edge: a new credit from the interval timer, and a refresh issue that consumes a credit. The bench withholds the grant for a chosen number of clocks so that the grant edge, and with it the first refresh, coincides exactly with a timer expiry. It then judges the total number of refresh commands in the tenure, which must be the credits owed with none dropped or counted twice. A second long deferral pushes the count past the saturation limit while a further credit arrives mid-drain, and the refresh total is compared against the saturated figure.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_PRE,
    ST_REF
  } rfsh_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam sd_cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam sd_cmd_t CMD_PREA  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  localparam sd_cmd_t CMD_AREF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

  function automatic longint unsigned ceil_div(longint unsigned num, longint unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int TREFI_CYC = 3120,
  parameter int TREF_CYC  = 6400000,
  parameter int BURST_CNT = 2048,
  parameter int ADD_W     = 12,
  localparam int MAX_CYC  = (TREF_CYC > TREFI_CYC) ? TREF_CYC : TREFI_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_i,
  output logic             tick_o,
  output logic [ADD_W-1:0] add_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = burst_i ? CNT_W'(TREF_CYC - 1) : CNT_W'(TREFI_CYC - 1);
  assign tick_o = (cnt_q >= lim);
  assign add_o  = burst_i ? ADD_W'(BURST_CNT) : ADD_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: expiries are never adjacent when the interval is longer than one clock
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && TREFI_CYC > 1 && TREF_CYC > 1) |=> !tick_o);

endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend #(
  parameter int PEND_MAX = 4096,
  parameter int ADD_W    = 12,
  localparam int PEND_W  = $clog2(PEND_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ADD_W-1:0] add_i,
  input  logic             dec_i,
  output logic             nz_o
);

  logic [PEND_W-1:0] cnt_q;
  logic [31:0]       sum;

  // credit and issue on the same edge net out
  assign sum  = 32'(cnt_q) + (tick_i ? 32'(add_i) : 32'd0) - 32'(dec_i);
  assign nz_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (sum > 32'(PEND_MAX))   cnt_q <= PEND_W'(PEND_MAX);
    else                            cnt_q <= PEND_W'(sum);
  end

  // R9: a refresh is only consumed against an existing credit
  p_dec_needs_credit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);

  // R10: count never exceeds the ceiling
  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= 32'(PEND_MAX));

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
  import sdram_rfsh_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int TRC_CYC   = 13,
  parameter int TRP_CYC   = 4,
  localparam int MAX_W    = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC,
  localparam int WAIT_W   = $clog2(MAX_W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pend_nz_i,
  input  logic                 gnt_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  output logic                 req_o,
  output logic                 dec_o,
  output sd_cmd_t              cmd_o
);

  rfsh_state_e       state_q, state_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic              first_q, first_d;
  logic              pick;

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    first_d = 1'b0;
    pick    = 1'b0;
    dec_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (pend_nz_i) state_d = ST_REQ;
      ST_REQ:  if (gnt_i) pick = 1'b1;
      ST_PRE, ST_REF: begin
        if (wcnt_q != '0) wcnt_d = wcnt_q - 1'b1;
        else              pick   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (pick) begin
      if (!pend_nz_i) begin
        state_d = ST_IDLE;
      end else if (|bank_open_i) begin
        state_d = ST_PRE;
        wcnt_d  = WAIT_W'(TRP_CYC - 1);
        first_d = 1'b1;
      end else begin
        state_d = ST_REF;
        wcnt_d  = WAIT_W'(TRC_CYC - 1);
        first_d = 1'b1;
        dec_o   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wcnt_q  <= '0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
      first_q <= first_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:  cmd_o = first_q ? CMD_PREA : CMD_NOP;
      ST_REF:  cmd_o = first_q ? CMD_AREF : CMD_NOP;
      default: cmd_o = CMD_DESEL;
    endcase
  end

  assign req_o = (state_q != ST_IDLE);

  // R7: refresh only reaches the pins with every bank closed
  p_ref_banks_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_AREF) |-> bank_open_i == '0);

  // R8: a refresh is followed by a NOP when the cycle time exceeds one clock
  p_nop_after_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_AREF && TRC_CYC > 1) |=> cmd_o == CMD_NOP);

  // R4: pins stay deselected without a request
  p_desel_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> cmd_o.cs_n);

  // R5: a sampled grant starts a command on the next clock
  p_grant_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ && gnt_i && pend_nz_i) |=> !cmd_o.cs_n && !cmd_o.ras_n);

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import sdram_rfsh_pkg::*;
#(
  parameter longint unsigned CLK_PERIOD_PS = 5000,
  parameter longint unsigned TRC_PS        = 63000,
  parameter longint unsigned TRP_PS        = 20000,
  parameter longint unsigned TREFI_PS      = 15600000,
  parameter longint unsigned TREF_PS       = 64'd32000000000,
  parameter int              BURST_CNT     = 2048,
  parameter int              PEND_MAX      = 4096,
  parameter int              NUM_BANKS     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 burst_mode_i,
  input  logic [NUM_BANKS-1:0] bank_open_i,
  input  logic                 gnt_i,
  output logic                 req_o,
  output logic                 cke_o,
  output logic                 cs_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic                 a10_o
);

  localparam int TRC_RAW   = int'(ceil_div(TRC_PS, CLK_PERIOD_PS));
  localparam int TRP_RAW   = int'(ceil_div(TRP_PS, CLK_PERIOD_PS));
  localparam int TRC_CYC   = (TRC_RAW < 1) ? 1 : TRC_RAW;
  localparam int TRP_CYC   = (TRP_RAW < 1) ? 1 : TRP_RAW;
  localparam int TREFI_CYC = int'(ceil_div(TREFI_PS, CLK_PERIOD_PS));
  localparam int TREF_CYC  = int'(ceil_div(TREF_PS, CLK_PERIOD_PS));
  localparam int ADD_W     = $clog2(BURST_CNT + 1);

  logic             tick;
  logic [ADD_W-1:0] add;
  logic             pend_nz;
  logic             dec;
  sd_cmd_t          cmd;

  rfsh_timer #(
    .TREFI_CYC (TREFI_CYC),
    .TREF_CYC  (TREF_CYC),
    .BURST_CNT (BURST_CNT),
    .ADD_W     (ADD_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .burst_i (burst_mode_i),
    .tick_o  (tick),
    .add_o   (add)
  );

  rfsh_pend #(
    .PEND_MAX (PEND_MAX),
    .ADD_W    (ADD_W)
  ) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .add_i  (add),
    .dec_i  (dec),
    .nz_o   (pend_nz)
  );

  rfsh_fsm #(
    .NUM_BANKS (NUM_BANKS),
    .TRC_CYC   (TRC_CYC),
    .TRP_CYC   (TRP_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_nz_i   (pend_nz),
    .gnt_i       (gnt_i),
    .bank_open_i (bank_open_i),
    .req_o       (req_o),
    .dec_o       (dec),
    .cmd_o       (cmd)
  );

  assign cke_o   = 1'b1;
  assign cs_n_o  = cmd.cs_n;
  assign ras_n_o = cmd.ras_n;
  assign cas_n_o = cmd.cas_n;
  assign we_n_o  = cmd.we_n;
  assign a10_o   = cmd.a10;

endmodule

// File: tb/sdram_refresh_sched_tb_top.sv
module sdram_refresh_sched_tb_top;

  localparam longint unsigned CLK_PS = 20000;
  localparam int TRC = int'((70000 + CLK_PS - 1) / CLK_PS);    // 4
  localparam int TRP = int'((50000 + CLK_PS - 1) / CLK_PS);    // 3
  localparam int LI  = 40;
  localparam int LB  = 400;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;

  typedef struct packed {
    logic        burst;
    logic [1:0]  open;
    logic [15:0] delay;
    logic [7:0]  npre;
    logic [7:0]  nref;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 2'b00, 16'd0,   8'd0, 8'd1},   // single distributed
    '{1'b0, 2'b01, 16'd0,   8'd1, 8'd1},   // open bank -> precharge first
    '{1'b0, 2'b00, 16'd50,  8'd0, 8'd2},   // two deferred
    '{1'b0, 2'b00, 16'd90,  8'd0, 8'd3},   // three deferred
    '{1'b0, 2'b00, 16'd78,  8'd0, 8'd3},   // credit on the issue edge
    '{1'b0, 2'b00, 16'd460, 8'd0, 8'd11},  // saturate at 10, one more mid-drain
    '{1'b1, 2'b00, 16'd0,   8'd0, 8'd8},   // burst
    '{1'b1, 2'b10, 16'd5,   8'd1, 8'd8},   // burst with open bank
    '{1'b0, 2'b11, 16'd0,   8'd2, 8'd1}    // bank still open after first precharge
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       burst_mode_i = 1'b0;
  logic [1:0] bank_open_i = 2'b00;
  logic       gnt_i = 1'b0;
  logic       req_o, cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, a10_o;

  int checks = 0;
  int errors = 0;

  always #10ns clk_i = ~clk_i;

  sdram_refresh_sched #(
    .CLK_PERIOD_PS (CLK_PS),
    .TRC_PS        (70000),
    .TRP_PS        (50000),
    .TREFI_PS      (800000),
    .TREF_PS       (8000000),
    .BURST_CNT     (8),
    .PEND_MAX      (10),
    .NUM_BANKS     (2)
  ) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .burst_mode_i (burst_mode_i),
    .bank_open_i  (bank_open_i),
    .gnt_i        (gnt_i),
    .req_o        (req_o),
    .cke_o        (cke_o),
    .cs_n_o       (cs_n_o),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o),
    .we_n_o       (we_n_o),
    .a10_o        (a10_o)
  );

  function automatic logic [3:0] pins();
    return {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic burst);
    rst_ni = 1'b0;
    gnt_i = 1'b0;
    bank_open_i = 2'b00;
    burst_mode_i = burst;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wait_req(output int n, output int desel_bad);
    n = 0;
    desel_bad = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (!req_o && (pins() != 4'b1111 || a10_o)) desel_bad++;
    end while (!req_o && n < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: state held in reset
    do_reset(1'b0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(req_o == 1'b0, "R11 req in reset", int'(req_o), 0);
    chk(pins() == 4'b1111 && !a10_o, "R11 pins in reset", int'({pins(), a10_o}), 30);
    chk(cke_o == 1'b1, "R7 cke in reset", int'(cke_o), 1);

    for (int r = 0; r < NROWS; r++) begin
      automatic row_t rw = ROWS[r];
      automatic int n, dbad, cyc, npre, nref, last_cyc, last_kind, first_cyc;
      automatic int gap_bad, nop_bad, a10_bad, cke_bad, exp_gap;
      automatic logic [3:0] c;

      do_reset(rw.burst);
      wait_req(n, dbad);
      // R2 / R3: first request after the interval plus one clock
      chk(n == (rw.burst ? LB : LI) + 1, rw.burst ? "R3 first request" : "R2 first request",
          n, (rw.burst ? LB : LI) + 1);
      bank_open_i = rw.open;
      for (int d = 0; d < int'(rw.delay); d++) begin
        @(negedge clk_i);
        if (pins() != 4'b1111 || a10_o) dbad++;
      end
      chk(dbad == 0, "R4 deselect before grant", dbad, 0);
      gnt_i = 1'b1;

      cyc = 0; npre = 0; nref = 0; last_cyc = -1; last_kind = 0; first_cyc = -1;
      gap_bad = 0; nop_bad = 0; a10_bad = 0; cke_bad = 0;
      do begin
        @(negedge clk_i);
        cyc++;
        c = pins();
        if (!cke_o) cke_bad++;
        if (c == C_PRE || c == C_REF) begin
          if (first_cyc < 0) first_cyc = cyc;
          if (last_cyc >= 0) begin
            exp_gap = (last_kind == 1) ? TRP : TRC;
            if (cyc - last_cyc != exp_gap) gap_bad++;
          end
          last_cyc = cyc;
          if (c == C_PRE) begin
            last_kind = 1;
            npre++;
            if (!a10_o) a10_bad++;
            if (npre >= int'(rw.npre)) bank_open_i = 2'b00;
          end else begin
            last_kind = 2;
            nref++;
            if (a10_o) a10_bad++;
            if (bank_open_i != 2'b00) a10_bad++;
          end
        end else if (req_o && c != C_NOP) begin
          nop_bad++;
        end
      end while (req_o && cyc < 2000);
      gnt_i = 1'b0;

      chk(first_cyc == 1, "R5 first command after grant", first_cyc, 1);
      chk(npre == int'(rw.npre), "R6 precharge count", npre, int'(rw.npre));
      chk(nref == int'(rw.nref), "R9 R10 R3 refresh count", nref, int'(rw.nref));
      chk(gap_bad == 0, "R1 R8 command spacing", gap_bad, 0);
      chk(nop_bad == 0, "R8 NOP fill", nop_bad, 0);
      chk(a10_bad == 0, "R6 R7 a10 and bank state", a10_bad, 0);
      chk(cke_bad == 0, "R7 cke high", cke_bad, 0);
      chk(last_kind == 2 && cyc - last_cyc == TRC, "R8 release after last refresh",
          cyc - last_cyc, TRC);
    end

    // R11: asynchronous reset in the middle of a tenure
    begin
      automatic int n, dbad;
      do_reset(1'b0);
      wait_req(n, dbad);
      gnt_i = 1'b1;
      @(negedge clk_i);
      chk(pins() == C_REF, "R7 refresh before reset", int'(pins()), int'(C_REF));
      rst_ni = 1'b0;
      #1ns;
      chk(req_o == 1'b0, "R11 req cleared asynchronously", int'(req_o), 0);
      chk(pins() == 4'b1111, "R11 pins deselect asynchronously", int'(pins()), 15);
      gnt_i = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule